// File: doc/BRIEF.md
# SD Card Identification Sequencer

This block runs the host side of bringing an SD card from power-up to the selected state. It issues one command at a time to an external command engine and reads the 32-bit response word. It uses the outcome of the interface-condition query to choose between the legacy path and the version 2.0 path, and it repeats the operating-condition query until the card reports that power-up has finished. It then sorts the card into one of four kinds, collects the card's relative address and selects the card. At that point it raises `ready` and asks for the fast clock.

The engine handshake has two halves. On the request side there is a one-cycle `cmdStart`, with the index, argument and response kind held steady. On the reply side there is a one-cycle `cmdDone`, which may carry `cmdTimeout` (no response) or `cmdError` (bad CRC or index echo). Serialising bits onto the CMD line, moving data, and the clock and bus-width switches after identification are all left to the engine and to other logic.

Top module: `sd_ident_seq`

## Requirements
- R1: After reset, `cmdStart`, `ready`, `failed` and `fastClkReq` are low, `cardType` is 0 and `rca` is 0. Nothing is issued until `start` is seen. The first command is index 0 with argument 0 and response kind 0 (none).
- R2: The second command is index 8 with argument 0x000001AA and response kind 1 (short).
- R3: When index 8 answers, the response must have bits [7:0] equal to 0xAA and bits [11:8] equal to 0x1. Otherwise the sequence ends in the failed state and no further command is issued.
- R4: Each operating-condition query is index 55 with argument 0, followed by index 41. Index 41 carries argument bits [23:0] equal to `VDD_WINDOW` and bit 30 set only when index 8 answered. Both use response kind 1.
- R5: While response bit 31 of index 41 is clear, the sequencer waits `RETRY_WAIT` cycles and retries. After `MAX_TRIES` clear replies it fails.
- R6: `cardType` uses the codes 0 unusable, 1 legacy (v1.x), 2 v2 standard capacity and 3 high capacity. On the legacy path a finished reply gives 1 whatever bit 30 holds. On the v2 path bit 30 set gives 3 and bit 30 clear gives 2.
- R7: After classification the sequencer issues index 2 (response kind 2, long) and then index 3 (kind 1). It takes `rca` from response bits [31:16] of index 3. It then issues index 7 with argument `{rca,16'h0}` and kind 1.
- R8: `ready` rises after index 7 completes. `fastClkReq` is low everywhere except in the ready state.
- R9: The sequence ends in the failed state on any `cmdError`, and on any `cmdTimeout` except one on index 8. In the failed state `failed` stays high, `cardType` reads 0 and no command is issued until the next `start`.
- R10: `cmdStart` is a single-cycle pulse. Index and argument stay stable until `cmdDone`, and no new request starts before it.
- R11: A `start` pulse in the ready or failed state restarts the sequence from index 0. A `start` pulse while a sequence is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or restart) identification |
| cmdStart | output | 1 | One-cycle command request to the engine |
| cmdIndex | output | 6 | Command index |
| cmdArg | output | 32 | Command argument |
| cmdRespKind | output | 2 | Expected response: 0 none, 1 short, 2 long |
| cmdDone | input | 1 | Engine finished the current command |
| cmdTimeout | input | 1 | With `cmdDone`: no response arrived |
| cmdError | input | 1 | With `cmdDone`: response was corrupt |
| cmdResp | input | 32 | Response word (card status or condition bits) |
| cardType | output | 2 | Card classification code |
| rca | output | 16 | Captured relative card address |
| ready | output | 1 | Card selected, identification complete |
| failed | output | 1 | Sticky failure indication |
| fastClkReq | output | 1 | Request for the fast transfer clock |

## Verification
Two events can land on the same clock edge: a `start` pulse and the completion of an outstanding command. Because the sequencer must ignore `start` while it is running, the collision is a real hazard. The bench drives `start` high in the same cycle that it returns the finished reply to index 41. It then checks that the scoreboard still sees the rest of the expected sequence (indices 2, 3, 7) with no restart at index 0, and that the final classification is correct. A separate case retries a busy card until the attempt limit. The bench measures the gap from each busy reply to the next index 55 request.

// File: rtl/sdid_pkg.sv
package sdid_pkg;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_SHORT = 2'd1,
    RSP_LONG  = 2'd2
  } rspKindE;

  typedef enum logic [1:0] {
    CARD_NONE = 2'd0,
    CARD_V1   = 2'd1,
    CARD_V2SC = 2'd2,
    CARD_HC   = 2'd3
  } cardKindE;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GO_IDLE,
    ST_IF_COND,
    ST_APP_PRE,
    ST_OP_COND,
    ST_BACKOFF,
    ST_GET_ID,
    ST_GET_ADDR,
    ST_SELECT,
    ST_READY,
    ST_FAIL
  } stepE;

  // Strobes from control to datapath
  typedef struct packed {
    logic     clear;     // new sequence: wipe all captured state
    logic     setV2;     // interface-condition query answered correctly
    logic     incTry;    // one more busy operating-condition reply
    logic     loadWait;  // arm the retry back-off counter
    logic     takeAddr;  // latch relative address from response
    logic     setKind;   // store classification
    cardKindE kind;
    logic     markFail;  // failure: classification back to unusable
  } dpStrobeT;

endpackage

// File: rtl/sdid_dpath.sv
module sdid_dpath
  import sdid_pkg::*;
#(
  parameter int MAX_TRIES  = 100,
  parameter int RETRY_WAIT = 50000
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobeT    strobe,
  input  logic [15:0] respAddr,
  output logic        v2Path,
  output logic        lastTry,
  output logic        waitDone,
  output logic [15:0] rcaQ,
  output cardKindE    kindQ
);

  localparam int TRY_W  = $clog2(MAX_TRIES + 1);
  localparam int WAIT_W = (RETRY_WAIT < 2) ? 1 : $clog2(RETRY_WAIT + 1);

  logic [TRY_W-1:0] tryCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tryCnt <= '0;
      v2Path <= 1'b0;
      rcaQ   <= '0;
      kindQ  <= CARD_NONE;
    end else begin
      if (strobe.clear)       tryCnt <= '0;
      else if (strobe.incTry) tryCnt <= tryCnt + 1'b1;

      if (strobe.clear)      v2Path <= 1'b0;
      else if (strobe.setV2) v2Path <= 1'b1;

      if (strobe.clear)         rcaQ <= '0;
      else if (strobe.takeAddr) rcaQ <= respAddr;

      if (strobe.clear || strobe.markFail) kindQ <= CARD_NONE;
      else if (strobe.setKind)             kindQ <= strobe.kind;
    end
  end

  // Current busy reply is the last one allowed
  assign lastTry = (tryCnt == TRY_W'(MAX_TRIES - 1));

  generate
    if (RETRY_WAIT == 0) begin : g_noWait
      logic unusedLoad;
      assign unusedLoad = strobe.loadWait;
      assign waitDone   = 1'b1;
    end else begin : g_wait
      logic [WAIT_W-1:0] waitCnt;
      always_ff @(posedge clk) begin
        if (!rstN)                waitCnt <= '0;
        else if (strobe.loadWait) waitCnt <= WAIT_W'(RETRY_WAIT);
        else if (waitCnt != '0)   waitCnt <= waitCnt - 1'b1;
      end
      assign waitDone = (waitCnt == '0);
    end
  endgenerate

endmodule

// File: rtl/sdid_ctrl.sv
module sdid_ctrl
  import sdid_pkg::*;
#(
  parameter logic [23:0] VDD_WINDOW = 24'hFF8000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        cmdDone,
  input  logic        cmdTimeout,
  input  logic        cmdError,
  input  logic        respPwrDone,
  input  logic        respHiCap,
  input  logic [11:0] respEcho,
  input  logic        v2Path,
  input  logic        lastTry,
  input  logic        waitDone,
  input  logic [15:0] rcaQ,
  output logic        cmdStart,
  output logic [5:0]  cmdIndex,
  output logic [31:0] cmdArg,
  output rspKindE     cmdRespKind,
  output dpStrobeT    strobe,
  output logic        ready,
  output logic        failed,
  output logic        fastClkReq
);

  stepE step, stepNext;
  logic pending;
  logic isCmdStep;
  logic badEnd;

  assign isCmdStep = (step == ST_GO_IDLE) || (step == ST_IF_COND) ||
                     (step == ST_APP_PRE) || (step == ST_OP_COND) ||
                     (step == ST_GET_ID)  || (step == ST_GET_ADDR) ||
                     (step == ST_SELECT);
  assign cmdStart  = isCmdStep && !pending;

  always_comb begin
    cmdIndex    = 6'd0;
    cmdArg      = 32'd0;
    cmdRespKind = RSP_SHORT;
    case (step)
      ST_GO_IDLE:  cmdRespKind = RSP_NONE;
      ST_IF_COND:  begin cmdIndex = 6'd8;  cmdArg = 32'h0000_01AA; end
      ST_APP_PRE:  cmdIndex = 6'd55;
      ST_OP_COND:  begin cmdIndex = 6'd41; cmdArg = {1'b0, v2Path, 6'd0, VDD_WINDOW}; end
      ST_GET_ID:   begin cmdIndex = 6'd2;  cmdRespKind = RSP_LONG; end
      ST_GET_ADDR: cmdIndex = 6'd3;
      ST_SELECT:   begin cmdIndex = 6'd7;  cmdArg = {rcaQ, 16'd0}; end
      default:     cmdRespKind = RSP_NONE;
    endcase
  end

  // Only the interface-condition query may legitimately go unanswered
  assign badEnd = cmdError || (cmdTimeout && (step != ST_IF_COND));

  always_comb begin
    stepNext = step;
    strobe   = '0;
    case (step)
      ST_IDLE, ST_READY, ST_FAIL: begin
        if (start) begin
          strobe.clear = 1'b1;
          stepNext     = ST_GO_IDLE;
        end
      end
      ST_BACKOFF: if (waitDone) stepNext = ST_APP_PRE;
      default: begin
        if (pending && cmdDone) begin
          if (badEnd) begin
            strobe.markFail = 1'b1;
            stepNext        = ST_FAIL;
          end else begin
            case (step)
              ST_GO_IDLE: stepNext = ST_IF_COND;
              ST_IF_COND: begin
                if (cmdTimeout) begin
                  stepNext = ST_APP_PRE;
                end else if (respEcho == 12'h1AA) begin
                  strobe.setV2 = 1'b1;
                  stepNext     = ST_APP_PRE;
                end else begin
                  strobe.markFail = 1'b1;
                  stepNext        = ST_FAIL;
                end
              end
              ST_APP_PRE: stepNext = ST_OP_COND;
              ST_OP_COND: begin
                if (respPwrDone) begin
                  strobe.setKind = 1'b1;
                  strobe.kind    = !v2Path ? CARD_V1 : (respHiCap ? CARD_HC : CARD_V2SC);
                  stepNext       = ST_GET_ID;
                end else if (lastTry) begin
                  strobe.markFail = 1'b1;
                  stepNext        = ST_FAIL;
                end else begin
                  strobe.incTry   = 1'b1;
                  strobe.loadWait = 1'b1;
                  stepNext        = ST_BACKOFF;
                end
              end
              ST_GET_ID: stepNext = ST_GET_ADDR;
              ST_GET_ADDR: begin
                strobe.takeAddr = 1'b1;
                stepNext        = ST_SELECT;
              end
              ST_SELECT: stepNext = ST_READY;
              default:   stepNext = ST_FAIL;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step    <= ST_IDLE;
      pending <= 1'b0;
    end else begin
      step <= stepNext;
      if (cmdStart)                pending <= 1'b1;
      else if (pending && cmdDone) pending <= 1'b0;
    end
  end

  assign ready      = (step == ST_READY);
  assign failed     = (step == ST_FAIL);
  assign fastClkReq = ready;

endmodule

// File: rtl/sd_ident_seq.sv
module sd_ident_seq
  import sdid_pkg::*;
#(
  parameter int          MAX_TRIES  = 100,
  parameter int          RETRY_WAIT = 50000,
  parameter logic [23:0] VDD_WINDOW = 24'hFF8000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        cmdStart,
  output logic [5:0]  cmdIndex,
  output logic [31:0] cmdArg,
  output logic [1:0]  cmdRespKind,
  input  logic        cmdDone,
  input  logic        cmdTimeout,
  input  logic        cmdError,
  input  logic [31:0] cmdResp,
  output logic [1:0]  cardType,
  output logic [15:0] rca,
  output logic        ready,
  output logic        failed,
  output logic        fastClkReq
);

  dpStrobeT strobe;
  rspKindE  kindW;
  cardKindE cardW;
  logic     v2Path, lastTry, waitDone;
  logic     unusedRespNibble;

  assign unusedRespNibble = ^cmdResp[15:12];

  sdid_ctrl #(.VDD_WINDOW(VDD_WINDOW)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .cmdDone     (cmdDone),
    .cmdTimeout  (cmdTimeout),
    .cmdError    (cmdError),
    .respPwrDone (cmdResp[31]),
    .respHiCap   (cmdResp[30]),
    .respEcho    (cmdResp[11:0]),
    .v2Path      (v2Path),
    .lastTry     (lastTry),
    .waitDone    (waitDone),
    .rcaQ        (rca),
    .cmdStart    (cmdStart),
    .cmdIndex    (cmdIndex),
    .cmdArg      (cmdArg),
    .cmdRespKind (kindW),
    .strobe      (strobe),
    .ready       (ready),
    .failed      (failed),
    .fastClkReq  (fastClkReq)
  );

  sdid_dpath #(.MAX_TRIES(MAX_TRIES), .RETRY_WAIT(RETRY_WAIT)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .respAddr (cmdResp[31:16]),
    .v2Path   (v2Path),
    .lastTry  (lastTry),
    .waitDone (waitDone),
    .rcaQ     (rca),
    .kindQ    (cardW)
  );

  assign cmdRespKind = kindW;
  assign cardType    = cardW;

endmodule

// File: rtl/sdid_checker.sv
module sdid_checker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        cmdStart,
  input logic [5:0]  cmdIndex,
  input logic [31:0] cmdArg,
  input logic [1:0]  cmdRespKind,
  input logic        cmdDone,
  input logic [1:0]  cardType,
  input logic [15:0] rca,
  input logic        ready,
  input logic        failed,
  input logic        fastClkReq
);

  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rstN)         outstanding <= 1'b0;
    else if (cmdStart) outstanding <= 1'b1;
    else if (cmdDone)  outstanding <= 1'b0;
  end

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart);

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> !cmdStart);

  p_hold_request_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outstanding && !cmdDone) |=> ($stable(cmdIndex) && $stable(cmdArg)));

  p_if_cond_arg_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && cmdIndex == 6'd8) |-> (cmdArg == 32'h0000_01AA && cmdRespKind == 2'd1));

  p_select_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && cmdIndex == 6'd7) |-> (cmdArg == {rca, 16'd0}));

  p_slow_clock_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> !fastClkReq);

  p_ready_kind_r6: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (cardType != 2'd0));

  p_fail_kind_r9: assert property (@(posedge clk) disable iff (!rstN)
    failed |-> (cardType == 2'd0 && !ready && !cmdStart));

  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (failed && !start) |=> failed);

endmodule

bind sd_ident_seq sdid_checker u_chk (.*);

// File: tb/tb_sd_ident_seq.sv
module tb_sd_ident_seq;

  localparam int WAITC = 5;
  localparam int TRIES = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startMain = 1'b0, pokeStart = 1'b0;
  logic start;
  logic cmdDone = 1'b0, cmdTimeout = 1'b0, cmdError = 1'b0;
  logic [31:0] cmdResp = '0;
  logic cmdStart, ready, failed, fastClkReq;
  logic [5:0] cmdIndex;
  logic [31:0] cmdArg;
  logic [1:0] cmdRespKind, cardType;
  logic [15:0] rca;

  assign start = startMain | pokeStart;
  always #10 clk = ~clk;

  sd_ident_seq #(.MAX_TRIES(TRIES), .RETRY_WAIT(WAITC)) dut (
    .clk(clk), .rstN(rstN), .start(start), .cmdStart(cmdStart),
    .cmdIndex(cmdIndex), .cmdArg(cmdArg), .cmdRespKind(cmdRespKind),
    .cmdDone(cmdDone), .cmdTimeout(cmdTimeout), .cmdError(cmdError),
    .cmdResp(cmdResp), .cardType(cardType), .rca(rca), .ready(ready),
    .failed(failed), .fastClkReq(fastClkReq));

  typedef struct {
    string       req;
    int          idx;
    logic [31:0] arg;
    int          kind;
  } expT;

  expT expQ[$];
  int checkCnt = 0, failCnt = 0, cyc = 0;
  bit finished = 0;

  // Card model settings
  int cmd8Mode = 0;   // 0 good echo, 1 no answer, 2 wrong echo
  int busyLeft = 0;
  bit alwaysBusy = 0, hiCap = 0, noAnswer41 = 0;
  logic [15:0] rcaVal = 16'h0;
  int errIdx = -1, pokeIdx = -1, lastBusyCyc = -1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expectCmd(string req, int idx, logic [31:0] arg, int kind);
    expT e;
    e.req = req; e.idx = idx; e.arg = arg; e.kind = kind;
    expQ.push_back(e);
  endtask

  task automatic expectAcmd41(bit cap);
    expectCmd("R4", 55, 32'h0, 1);
    expectCmd("R4", 41, {1'b0, cap, 6'd0, 24'hFF8000}, 1);
  endtask

  task automatic expectTail(logic [15:0] addr);
    expectCmd("R7", 2, 32'h0, 2);
    expectCmd("R7", 3, 32'h0, 1);
    expectCmd("R7", 7, {addr, 16'h0}, 1);
  endtask

  // Engine model and scoreboard monitor
  initial begin
    forever begin : engine
      int i;
      logic [31:0] a;
      int k;
      expT e;
      @(negedge clk);
      cmdDone = 0; cmdTimeout = 0; cmdError = 0; pokeStart = 0;
      if (rstN && cmdStart) begin
        i = int'(cmdIndex); a = cmdArg; k = int'(cmdRespKind);
        if (expQ.size() == 0) begin
          checkCnt++; failCnt++;
          $display("FAIL R9 unexpected command: actual %0d expected none", i);
        end else begin
          e = expQ.pop_front();
          check(e.req, 32'(i), 32'(e.idx), "index");
          check(e.req, a, e.arg, "argument");
          check(e.req, 32'(k), 32'(e.kind), "response kind");
        end
        if (i == 55 && lastBusyCyc >= 0) begin
          // R5: back-off between busy reply and next query
          check("R5", 32'((cyc - lastBusyCyc >= WAITC + 1) && (cyc - lastBusyCyc <= WAITC + 3)),
                32'd1, "retry gap in range");
          lastBusyCyc = -1;
        end
        repeat (2) @(negedge clk);
        cmdDone = 1; cmdResp = 32'h0000_0900;
        if (i == errIdx) cmdError = 1;
        else case (i)
          8: begin
            if (cmd8Mode == 0)      cmdResp = 32'h0000_01AA;
            else if (cmd8Mode == 1) cmdTimeout = 1;
            else                    cmdResp = 32'h0000_02AA;
          end
          41: begin
            if (noAnswer41) cmdTimeout = 1;
            else if (alwaysBusy || busyLeft > 0) begin
              busyLeft--;
              cmdResp = {1'b0, hiCap, 30'h00FF_8000};
              lastBusyCyc = cyc;
            end else cmdResp = {1'b1, hiCap, 30'h00FF_8000};
          end
          2: cmdResp = 32'h1357_9BDF;
          3: cmdResp = {rcaVal, 16'h0520};
          default: ;
        endcase
        if (i == pokeIdx) pokeStart = 1;
      end
    end
  end

  task automatic kick();
    @(negedge clk) startMain = 1;
    @(negedge clk) startMain = 0;
  endtask

  task automatic waitEnd(string req);
    int n = 0;
    int fastEarly = 0;
    while (!(ready || failed) && n < 5000) begin
      @(negedge clk);
      if (!ready && fastClkReq) fastEarly++;
      n++;
    end
    repeat (10) @(negedge clk);
    check("R8", 32'(fastEarly), 32'd0, "fast clock requested during identification");
    check(req, 32'(expQ.size()), 32'd0, "expected commands left unissued");
  endtask

  task automatic setCard(int m8, int busy, bit cap, logic [15:0] addr);
    cmd8Mode = m8; busyLeft = busy; hiCap = cap; rcaVal = addr;
    alwaysBusy = 0; noAnswer41 = 0; errIdx = -1; pokeIdx = -1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    repeat (5) @(negedge clk);
    check("R1", 32'(cmdStart), 0, "request after reset");
    check("R1", 32'(ready), 0, "ready after reset");
    check("R1", 32'(failed), 0, "failed after reset");
    check("R1", 32'(cardType), 0, "type after reset");
    check("R1", 32'(rca), 0, "address after reset");
    check("R1", 32'(fastClkReq), 0, "clock request after reset");

    // High capacity with two busy replies
    setCard(0, 2, 1, 16'h1234);
    expectCmd("R1", 0, 32'h0, 0);
    expectCmd("R2", 8, 32'h1AA, 1);
    for (int t = 0; t < 3; t++) expectAcmd41(1);
    expectTail(16'h1234);
    kick(); waitEnd("R6");
    check("R8", 32'(ready), 1, "ready high capacity");
    check("R6", 32'(cardType), 3, "high capacity type");
    check("R7", 32'(rca), 32'h1234, "captured address");
    check("R8", 32'(fastClkReq), 1, "fast clock when ready");

    // Standard capacity v2; start collides with the finishing query
    setCard(0, 0, 0, 16'hBEEF);
    pokeIdx = 41;
    expectCmd("R11", 0, 32'h0, 0);
    expectCmd("R2", 8, 32'h1AA, 1);
    expectAcmd41(1);
    expectTail(16'hBEEF);
    kick(); waitEnd("R11");
    check("R6", 32'(cardType), 2, "v2 standard type");
    check("R11", 32'(rca), 32'hBEEF, "address after ignored start");

    // Legacy card: no answer to 8, bit 30 set but ignored
    setCard(1, 1, 1, 16'h0042);
    expectCmd("R1", 0, 32'h0, 0);
    expectCmd("R2", 8, 32'h1AA, 1);
    expectAcmd41(0); expectAcmd41(0);
    expectTail(16'h0042);
    kick(); waitEnd("R6");
    check("R6", 32'(cardType), 1, "legacy type");
    check("R8", 32'(ready), 1, "legacy ready");

    // Wrong echo
    setCard(2, 0, 0, 16'h0);
    expectCmd("R1", 0, 32'h0, 0);
    expectCmd("R3", 8, 32'h1AA, 1);
    kick(); waitEnd("R3");
    check("R3", 32'(failed), 1, "failed on wrong echo");
    check("R3", 32'(cardType), 0, "type on wrong echo");
    repeat (20) @(negedge clk);
    check("R9", 32'(failed), 1, "failure stays");

    // Legacy path, operating-condition query unanswered
    setCard(1, 0, 0, 16'h0);
    noAnswer41 = 1;
    expectCmd("R1", 0, 32'h0, 0);
    expectCmd("R2", 8, 32'h1AA, 1);
    expectAcmd41(0);
    kick(); waitEnd("R9");
    check("R9", 32'(failed), 1, "failed on unanswered 41");
    check("R9", 32'(ready), 0, "not ready after unanswered 41");

    // Card busy forever: attempt limit
    setCard(0, 0, 0, 16'h0);
    alwaysBusy = 1;
    expectCmd("R1", 0, 32'h0, 0);
    expectCmd("R2", 8, 32'h1AA, 1);
    for (int t = 0; t < TRIES; t++) expectAcmd41(1);
    kick(); waitEnd("R5");
    check("R5", 32'(failed), 1, "failed after attempt limit");
    lastBusyCyc = -1;

    // Error on long-response command after classification
    setCard(0, 0, 1, 16'h0);
    errIdx = 2;
    expectCmd("R1", 0, 32'h0, 0);
    expectCmd("R2", 8, 32'h1AA, 1);
    expectAcmd41(1);
    expectCmd("R9", 2, 32'h0, 2);
    kick(); waitEnd("R9");
    check("R9", 32'(failed), 1, "failed on command error");
    check("R9", 32'(cardType), 0, "type cleared on failure");

    // Restart from failed state
    setCard(0, 0, 1, 16'h7001);
    expectCmd("R11", 0, 32'h0, 0);
    expectCmd("R2", 8, 32'h1AA, 1);
    expectAcmd41(1);
    expectTail(16'h7001);
    kick(); waitEnd("R11");
    check("R11", 32'(failed), 0, "failure cleared by restart");
    check("R11", 32'(cardType), 3, "type after restart");

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule